// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Unit

This unit sits between a 32-bit register datapath and a word-wide, byte-addressed data memory. For every request it adds a base register value to a sign-extended 16-bit displacement to form the effective address. It then drives a single-cycle memory port with the word address, byte enables and lane-steered write data. The memory answers in the same cycle.

Five operations are handled: word load, word store, signed byte load, unsigned byte load and byte store. Lanes are mapped big-endian, so the byte whose address ends in binary 00 is the most significant byte of the word. A word access whose effective address is not a multiple of four is refused. The unit flags it, blocks the write, and returns zero as the load result. Load results are registered and appear one cycle after the request.

Top module: `be_lane_lsu`

## Requirements
- R1: The effective address is `base + sign_extend(disp)` modulo 2^32. `mem_addr` carries it with bits [1:0] forced to zero, in the request cycle.
- R2: The op code on `op` is 000 word load, 001 word store, 010 signed byte load, 011 unsigned byte load and 100 byte store. A load request accepted in cycle N gives `ld_valid` high with its result in cycle N+1. `ld_valid` is low in every cycle that does not follow a load request.
- R3: Byte lanes are big-endian. Address bits [1:0] equal to 0, 1, 2 or 3 select word bits [31:24], [23:16], [15:8] or [7:0].
- R4: A signed byte load copies bit 7 of the selected byte into result bits [31:8].
- R5: An unsigned byte load sets result bits [31:8] to zero.
- R6: A byte store places register bits [7:0] on all four lanes of `mem_wdata`. It raises only the enable bit `mem_be[3 - addr[1:0]]`, so the other three bytes of the memory word keep their values.
- R7: A word store drives `mem_wdata = st_data` with `mem_be = 4'b1111`. A word load returns the whole memory word unchanged.
- R8: A word access with address bits [1:0] not equal to 00 raises `align_err` in the request cycle. It keeps `mem_req` and `mem_we` low, so memory is not changed. If it is a load, it yields `ld_valid` with zero data. Byte accesses never raise `align_err`.
- R9: During and after reset, and before any load, `ld_valid` and `ld_data` are zero.
- R10: Op codes 101, 110 and 111 are ignored. They raise no `mem_req`, no `mem_we`, no `align_err` and no `ld_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation code (see R2) |
| base | input | 32 | Base register value |
| disp | input | 16 | Signed byte displacement |
| st_data | input | 32 | Register value to store |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte enables, bit 3 = bits [31:24] |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Word returned by memory in the request cycle |
| align_err | output | 1 | Misaligned word access flag |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The memory-side outputs `mem_req`, `mem_we`, `mem_addr`, `mem_be`, `mem_wdata` and `align_err` are combinational in the request itself. The bench samples them a short delay after it drives a request at the falling edge, in the same cycle. A load result is due exactly one rising edge later. The driver pushes every expected load result into a queue, and a monitor sampling a quarter period after each rising edge pops and compares it. A result that appears early, late or with no request behind it is a mismatch. Stored bytes are checked with later word loads, against a shadow memory that the bench updates from the requirements.

// File: rtl/be_lane_lsu.sv
module be_lane_lsu #(
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        op,
  input  logic [31:0]       base,
  input  logic [DISP_W-1:0] disp,
  input  logic [31:0]       st_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              align_err,
  output logic              ld_valid,
  output logic [31:0]       ld_data
);
  localparam logic [2:0] OP_LDW = 3'd0;
  localparam logic [2:0] OP_STW = 3'd1;
  localparam logic [2:0] OP_LDB = 3'd2;
  localparam logic [2:0] OP_LDBU = 3'd3;
  localparam logic [2:0] OP_STB = 3'd4;

  logic [31:0] ea;
  logic        is_word, is_load, is_store, known, misal;
  logic [7:0]  lane_byte;
  logic [31:0] ext;

  assign ea       = base + {{(32-DISP_W){disp[DISP_W-1]}}, disp};
  assign is_word  = (op == OP_LDW) || (op == OP_STW);
  assign is_load  = (op == OP_LDW) || (op == OP_LDB) || (op == OP_LDBU);
  assign is_store = (op == OP_STW) || (op == OP_STB);
  assign known    = is_load || is_store;
  assign misal    = req_valid && is_word && (ea[1:0] != 2'b00);

  assign align_err = misal;
  assign mem_req   = req_valid && known && !misal;
  assign mem_we    = mem_req && is_store;
  assign mem_addr  = {ea[31:2], 2'b00};
  assign mem_wdata = (op == OP_STB) ? {4{st_data[7:0]}} : st_data;

  always_comb begin
    mem_be = 4'b0000;
    if (mem_req) begin
      if (is_word) mem_be = 4'b1111;
      else         mem_be = 4'b1000 >> ea[1:0];
    end
  end

  always_comb begin
    case (ea[1:0])
      2'd0:    lane_byte = mem_rdata[31:24];
      2'd1:    lane_byte = mem_rdata[23:16];
      2'd2:    lane_byte = mem_rdata[15:8];
      default: lane_byte = mem_rdata[7:0];
    endcase
  end

  always_comb begin
    if (misal)                ext = '0;
    else if (op == OP_LDW)    ext = mem_rdata;
    else if (op == OP_LDB)    ext = {{24{lane_byte[7]}}, lane_byte};
    else                      ext = {24'h0, lane_byte};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= req_valid && is_load;
      if (req_valid && is_load) ld_data <= ext;
    end
  end

  // R8
  misal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!mem_we && !mem_req));

  // R8
  misal_zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (align_err && is_load) |=> (ld_valid && ld_data == 32'h0));

  // R6
  byte_store_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && op == OP_STB) |-> ($countones(mem_be) == 1));

  // R7
  word_store_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && op == OP_STW) |-> (mem_be == 4'b1111));

  // R2
  load_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_load) |=> ld_valid);

  // R5
  unsigned_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_LDBU) |=> (ld_data[31:8] == 24'h0));

  // R10
  unknown_op_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !known) |-> (!mem_req && !align_err));
endmodule

// File: tb/tb_be_lane_lsu.sv
module tb_be_lane_lsu;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] base = '0;
  logic [15:0] disp = '0;
  logic [31:0] st_data = '0;
  logic        mem_req, mem_we, align_err, ld_valid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, ld_data;
  logic [3:0]  mem_be;

  logic [31:0] mem [0:15];
  logic [31:0] shadow [0:15];
  logic [31:0] expq [$];
  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  be_lane_lsu dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .base(base),
    .disp(disp), .st_data(st_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .align_err(align_err), .ld_valid(ld_valid),
    .ld_data(ld_data)
  );

  assign mem_rdata = mem[mem_addr[5:2]];

  always @(posedge clk) begin
    if (mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[5:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n) begin
      if (ld_valid) begin
        if (expq.size() == 0) chk("R2 unexpected ld_valid", 32'h1, 32'h0);
        else chk("R2 load result", ld_data, expq.pop_front());
      end else if (expq.size() != 0) begin
        chk("R2 missing ld_valid", 32'h0, 32'h1);
        void'(expq.pop_front());
      end
    end
  end

  task automatic drive(input logic [2:0] o, input logic [31:0] b, input logic [15:0] d,
                       input logic [31:0] sd, input string tag);
    logic [31:0] ea, w, exp_ld;
    logic [7:0]  by;
    logic        wordop, mis, ld, st;
    @(negedge clk);
    req_valid = 1'b1; op = o; base = b; disp = d; st_data = sd;
    #1;
    ea = b + {{16{d[15]}}, d};
    wordop = (o == 3'd0) || (o == 3'd1);
    ld = (o == 3'd0) || (o == 3'd2) || (o == 3'd3);
    st = (o == 3'd1) || (o == 3'd4);
    mis = wordop && (ea[1:0] != 2'b00);
    chk({tag, " R8 align_err"}, {31'h0, align_err}, {31'h0, mis});
    chk({tag, " R10 mem_req"}, {31'h0, mem_req}, {31'h0, (ld || st) && !mis});
    chk({tag, " R8 mem_we"}, {31'h0, mem_we}, {31'h0, st && !mis});
    if ((ld || st) && !mis) chk({tag, " R1 mem_addr"}, mem_addr, {ea[31:2], 2'b00});
    if (o == 3'd4 && !mis) begin
      chk({tag, " R6 byte enables"}, {28'h0, mem_be}, {28'h0, 4'b1000 >> ea[1:0]});
      chk({tag, " R6 lane data"}, mem_wdata, {4{sd[7:0]}});
      shadow[ea[5:2]][(3 - ea[1:0])*8 +: 8] = sd[7:0];
    end
    if (o == 3'd1 && !mis) begin
      chk({tag, " R7 byte enables"}, {28'h0, mem_be}, 32'hF);
      chk({tag, " R7 write data"}, mem_wdata, sd);
      shadow[ea[5:2]] = sd;
    end
    if (ld) begin
      w = shadow[ea[5:2]];
      by = w[(3 - ea[1:0])*8 +: 8];
      if (mis)             exp_ld = 32'h0;
      else if (o == 3'd0)  exp_ld = w;
      else if (o == 3'd2)  exp_ld = {{24{by[7]}}, by};
      else                 exp_ld = {24'h0, by};
      expq.push_back(exp_ld);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; op = 3'd0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = (i * 32'h0101_0101) ^ 32'hA5C3_3C5A;
      shadow[i] = mem[i];
    end
    mem[0] = 32'h817F_00FE;
    shadow[0] = 32'h817F_00FE;
    #(CLK_P*2 + 2);
    chk("R9 reset ld_valid", {31'h0, ld_valid}, 32'h0);
    chk("R9 reset ld_data", ld_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after reset ld_valid", {31'h0, ld_valid}, 32'h0);

    drive(3'd0, 32'h0, 16'h0, '0, "R7 word load addr0");
    drive(3'd0, 32'h8, 16'hFFFC, '0, "R1 negative disp");
    drive(3'd0, 32'h0, 16'h000C, '0, "R1 positive disp");
    drive(3'd2, 32'h0, 16'h0, '0, "R3 R4 lb lane0");
    drive(3'd2, 32'h0, 16'h1, '0, "R3 R4 lb lane1");
    drive(3'd2, 32'h2, 16'h0, '0, "R3 R4 lb lane2");
    drive(3'd2, 32'h4, 16'hFFFF, '0, "R3 R4 lb lane3");
    drive(3'd3, 32'h0, 16'h0, '0, "R5 lbu lane0");
    drive(3'd3, 32'h0, 16'h3, '0, "R5 lbu lane3");
    idle();
    drive(3'd4, 32'h4, 16'h1, 32'h1234_5699, "R6 sb lane1");
    idle();
    drive(3'd0, 32'h4, 16'h0, '0, "R6 neighbours kept");
    drive(3'd4, 32'h8, 16'h3, 32'h0000_0080, "R6 sb lane3");
    drive(3'd2, 32'h8, 16'h3, '0, "R4 stored byte sign");
    drive(3'd1, 32'h10, 16'hFFFC, 32'hDEAD_BEEF, "R7 sw");
    drive(3'd0, 32'hC, 16'h0, '0, "R7 readback");
    drive(3'd0, 32'h0, 16'h2, '0, "R8 misaligned lw");
    drive(3'd1, 32'h4, 16'h3, 32'hFFFF_FFFF, "R8 misaligned sw");
    drive(3'd0, 32'h4, 16'h0, '0, "R8 memory unchanged");
    drive(3'd5, 32'h0, 16'h0, 32'h5555_5555, "R10 op5");
    drive(3'd7, 32'h4, 16'h0, 32'h5555_5555, "R10 op7");
    drive(3'd0, 32'h4, 16'h0, '0, "R10 memory unchanged");
    idle();
    idle();
    chk("R2 queue drained", expq.size(), 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P*5000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule